// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block is a fully associative translation cache for a paged memory system with 4 KiB pages. A request carries a 32-bit virtual address and a read/write flag. In the same cycle the block compares the upper 20 address bits against the tag of every valid entry. On a match it returns a 30-bit physical address, built from the entry's 18-bit frame number and the untranslated low 12 bits. When nothing matches it raises a miss exception. When a store matches an entry that does not allow writes, it raises a protection exception instead.

Each entry keeps its own modified and accessed status. A completed store marks the entry modified. Any completed translation marks it accessed, and a clear input lets the replacement policy in software age all accessed flags at once. There is no hardware table walker. The exception handler installs translations through a fill port that writes a chosen slot, and a flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any request raises miss_exc_o=1 with hit_o=0 and paddr_o=0.
- R2: A request whose bits 31..12 equal the tag of a valid entry that permits the access drives hit_o=1 and paddr_o={entry frame number, req_vaddr_i[11:0]} in the same cycle as req_valid_i. hit_idx_o gives the slot.
- R3: A request that matches no valid entry drives miss_exc_o=1, hit_o=0 and paddr_o=0.
- R4: A write (req_write_i=1) that matches an entry whose write-permission bit is 0 drives wprot_exc_o=1, hit_o=0, miss_exc_o=0 and paddr_o=0. It leaves the entry's modified and accessed flags unchanged, and a read of the same entry still hits.
- R5: miss_exc_o and wprot_exc_o are never high together. With req_valid_i=0, hit_o, miss_exc_o and wprot_exc_o are all 0 and paddr_o=0.
- R6: A write that completes a hit sets the entry's modified flag from the next cycle. hit_dirty_o shows the flag as it stood before the current access.
- R7: Every completed hit sets the entry's accessed flag, which hit_ref_o shows before the current access. A one-cycle clr_ref_i pulse clears all accessed flags, except that an entry completing a hit in that same cycle ends with the flag set.
- R8: A fill (fill_valid_i=1) writes tag, frame number and write permission into slot fill_idx_i with valid=1, modified=0 and accessed=0.
- R9: A fill whose tag equals the tag of a valid entry in another slot invalidates that other entry, so at most one entry ever matches.
- R10: A request made in the same cycle as a fill sees the contents from before the fill.
- R11: flush_i clears every valid bit in one cycle. A fill in the same cycle is dropped.
- R12: When a completed hit and a fill target the same slot in the same cycle, the fill wins: the slot ends with modified=0 and accessed=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_write_i | input | 1 | Request is a store |
| req_vaddr_i | input | 32 | Virtual address |
| hit_o | output | 1 | Translation completed |
| paddr_o | output | 30 | Physical address, 0 unless hit_o |
| hit_idx_o | output | 4 | Slot that matched |
| hit_dirty_o | output | 1 | Matching slot's modified flag before this access |
| hit_ref_o | output | 1 | Matching slot's accessed flag before this access |
| miss_exc_o | output | 1 | No valid entry matched |
| wprot_exc_o | output | 1 | Store to a page without write permission |
| fill_valid_i | input | 1 | Install an entry |
| fill_idx_i | input | 4 | Slot to write |
| fill_vpn_i | input | 20 | Virtual page tag to install |
| fill_ppn_i | input | 18 | Frame number to install |
| fill_wr_ok_i | input | 1 | Write permission of the new entry |
| flush_i | input | 1 | Invalidate all entries |
| clr_ref_i | input | 1 | Clear all accessed flags |

## Verification
On every cycle the assertions check that the two exceptions are exclusive, that an idle cycle drives nothing, and that the page offset passes through on a hit. They also check that at most one slot matches, and that the state changes after a fill, a flush, a completed store and an accessed-flag clear take effect one cycle later. The frame number actually returned, the slot chosen after a duplicate fill, and the same-cycle orderings can only be shown by the bench's scenarios. Those orderings are lookup against fill, fill against update, flush against fill, and hit against clear, and each depends on a particular sequence of installs.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PAGE_OFF_W_DEF = 12;
  localparam int unsigned VADDR_W_DEF    = 32;
  localparam int unsigned PADDR_W_DEF    = 30;

  typedef enum logic [1:0] {
    RES_IDLE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_WPROT = 2'd3
  } xlate_res_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PPN_W       = 18,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              clr_ref_i,
  input  logic                              fill_en_i,
  input  logic [IDX_W-1:0]                  fill_idx_i,
  input  logic [VPN_W-1:0]                  fill_vpn_i,
  input  logic [PPN_W-1:0]                  fill_ppn_i,
  input  logic                              fill_wr_ok_i,
  input  logic                              upd_en_i,
  input  logic [IDX_W-1:0]                  upd_idx_i,
  input  logic                              upd_dirty_i,
  output logic [NUM_ENTRIES-1:0]            valid_o,
  output logic [NUM_ENTRIES-1:0]            dirty_o,
  output logic [NUM_ENTRIES-1:0]            ref_o,
  output logic [NUM_ENTRIES-1:0]            wr_ok_o,
  output logic [NUM_ENTRIES-1:0][VPN_W-1:0] tag_o,
  output logic [NUM_ENTRIES-1:0][PPN_W-1:0] ppn_o
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic fill_here, kill_dup, upd_here;

    // flush drops a concurrent fill
    assign fill_here = fill_en_i && !flush_i && (fill_idx_i == IDX_W'(e));
    // a new tag evicts any other copy of itself
    assign kill_dup  = fill_en_i && valid_o[e] && (tag_o[e] == fill_vpn_i) &&
                       (fill_idx_i != IDX_W'(e));
    assign upd_here  = upd_en_i && (upd_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[e] <= 1'b0;
        dirty_o[e] <= 1'b0;
        ref_o[e]   <= 1'b0;
        wr_ok_o[e] <= 1'b0;
        tag_o[e]   <= '0;
        ppn_o[e]   <= '0;
      end else begin
        if (flush_i)        valid_o[e] <= 1'b0;
        else if (fill_here) valid_o[e] <= 1'b1;
        else if (kill_dup)  valid_o[e] <= 1'b0;

        if (fill_here) begin
          tag_o[e]   <= fill_vpn_i;
          ppn_o[e]   <= fill_ppn_i;
          wr_ok_o[e] <= fill_wr_ok_i;
        end

        if (fill_here)                     dirty_o[e] <= 1'b0;
        else if (upd_here && upd_dirty_i)  dirty_o[e] <= 1'b1;

        if (fill_here)      ref_o[e] <= 1'b0;
        else if (upd_here)  ref_o[e] <= 1'b1;
        else if (clr_ref_i) ref_o[e] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned VPN_W       = 20,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0]            valid_i,
  input  logic [NUM_ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]                  vpn_i,
  output logic [NUM_ENTRIES-1:0]            hit_vec_o,
  output logic                              any_hit_o,
  output logic [IDX_W-1:0]                  hit_idx_o
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign hit_vec_o[e] = valid_i[e] && (tag_i[e] == vpn_i);
  end

  assign any_hit_o = |hit_vec_o;

  // one-hot by construction of the fill path, so an OR encoder suffices
  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
(
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic       any_hit_i,
  input  logic       sel_wr_ok_i,
  output xlate_res_e res_o,
  output logic       upd_en_o,
  output logic       upd_dirty_o
);

  always_comb begin
    if (!req_valid_i)                      res_o = RES_IDLE;
    else if (!any_hit_i)                   res_o = RES_MISS;
    else if (req_write_i && !sel_wr_ok_i)  res_o = RES_WPROT;
    else                                   res_o = RES_HIT;
  end

  assign upd_en_o    = (res_o == RES_HIT);
  assign upd_dirty_o = (res_o == RES_HIT) && req_write_i;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned VADDR_W     = VADDR_W_DEF,
  parameter int unsigned PADDR_W     = PADDR_W_DEF,
  parameter int unsigned PAGE_OFF_W  = PAGE_OFF_W_DEF,
  localparam int unsigned VPN_W      = VADDR_W - PAGE_OFF_W,
  localparam int unsigned PPN_W      = PADDR_W - PAGE_OFF_W,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [VADDR_W-1:0] req_vaddr_i,
  output logic               hit_o,
  output logic [PADDR_W-1:0] paddr_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               hit_dirty_o,
  output logic               hit_ref_o,
  output logic               miss_exc_o,
  output logic               wprot_exc_o,
  input  logic               fill_valid_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [PPN_W-1:0]   fill_ppn_i,
  input  logic               fill_wr_ok_i,
  input  logic               flush_i,
  input  logic               clr_ref_i
);

  logic [NUM_ENTRIES-1:0]            valid_vec, dirty_vec, ref_vec, wr_ok_vec, hit_vec;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] tag_arr;
  logic [NUM_ENTRIES-1:0][PPN_W-1:0] ppn_arr;
  logic                              any_hit, upd_en, upd_dirty;
  logic [IDX_W-1:0]                  sel_idx;
  xlate_res_e                        res;

  tlb_entry_array #(
    .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .clr_ref_i   (clr_ref_i),
    .fill_en_i   (fill_valid_i),
    .fill_idx_i  (fill_idx_i),
    .fill_vpn_i  (fill_vpn_i),
    .fill_ppn_i  (fill_ppn_i),
    .fill_wr_ok_i(fill_wr_ok_i),
    .upd_en_i    (upd_en),
    .upd_idx_i   (sel_idx),
    .upd_dirty_i (upd_dirty),
    .valid_o     (valid_vec),
    .dirty_o     (dirty_vec),
    .ref_o       (ref_vec),
    .wr_ok_o     (wr_ok_vec),
    .tag_o       (tag_arr),
    .ppn_o       (ppn_arr)
  );

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_i  (valid_vec),
    .tag_i    (tag_arr),
    .vpn_i    (req_vaddr_i[VADDR_W-1:PAGE_OFF_W]),
    .hit_vec_o(hit_vec),
    .any_hit_o(any_hit),
    .hit_idx_o(sel_idx)
  );

  tlb_prot u_prot (
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .any_hit_i  (any_hit),
    .sel_wr_ok_i(wr_ok_vec[sel_idx]),
    .res_o      (res),
    .upd_en_o   (upd_en),
    .upd_dirty_o(upd_dirty)
  );

  assign hit_o       = (res == RES_HIT);
  assign miss_exc_o  = (res == RES_MISS);
  assign wprot_exc_o = (res == RES_WPROT);
  assign hit_idx_o   = sel_idx;
  assign hit_dirty_o = hit_o && dirty_vec[sel_idx];
  assign hit_ref_o   = hit_o && ref_vec[sel_idx];
  assign paddr_o     = hit_o ? {ppn_arr[sel_idx], req_vaddr_i[PAGE_OFF_W-1:0]} : '0;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned VADDR_W     = 32,
  parameter int unsigned PADDR_W     = 30,
  parameter int unsigned PAGE_OFF_W  = 12,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic                   req_write_i,
  input logic [VADDR_W-1:0]     req_vaddr_i,
  input logic                   hit_o,
  input logic [PADDR_W-1:0]     paddr_o,
  input logic [IDX_W-1:0]       hit_idx_o,
  input logic                   miss_exc_o,
  input logic                   wprot_exc_o,
  input logic                   fill_valid_i,
  input logic [IDX_W-1:0]       fill_idx_i,
  input logic                   flush_i,
  input logic                   clr_ref_i,
  input logic [NUM_ENTRIES-1:0] valid_vec,
  input logic [NUM_ENTRIES-1:0] dirty_vec,
  input logic [NUM_ENTRIES-1:0] ref_vec,
  input logic [NUM_ENTRIES-1:0] hit_vec
);

  a_r5_exc_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_exc_o && wprot_exc_o));

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!hit_o && !miss_exc_o && !wprot_exc_o && paddr_o == '0));

  a_r2_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[PAGE_OFF_W-1:0] == req_vaddr_i[PAGE_OFF_W-1:0]));

  a_r3_miss_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_exc_o |-> (!hit_o && paddr_o == '0));

  a_r4_wprot_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wprot_exc_o |-> (req_write_i && !hit_o && paddr_o == '0));

  a_r6_dirty_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && req_write_i && !(fill_valid_i && fill_idx_i == hit_idx_o))
    |=> dirty_vec[$past(hit_idx_o)]);

  a_r7_clr_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ref_i && !hit_o) |=> (ref_vec == '0));

  a_r8_fill_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=> valid_vec[$past(fill_idx_i)]);

  a_r9_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  a_r11_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec == '0));

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .VADDR_W(VADDR_W), .PADDR_W(PADDR_W), .PAGE_OFF_W(PAGE_OFF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_vaddr_i (req_vaddr_i),
  .hit_o       (hit_o),
  .paddr_o     (paddr_o),
  .hit_idx_o   (hit_idx_o),
  .miss_exc_o  (miss_exc_o),
  .wprot_exc_o (wprot_exc_o),
  .fill_valid_i(fill_valid_i),
  .fill_idx_i  (fill_idx_i),
  .flush_i     (flush_i),
  .clr_ref_i   (clr_ref_i),
  .valid_vec   (valid_vec),
  .dirty_vec   (dirty_vec),
  .ref_vec     (ref_vec),
  .hit_vec     (hit_vec)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        hit, miss, wprot, hdirty, href;
  logic [29:0] paddr;
  logic [3:0]  hidx;
  logic        fill_valid = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0, clr_ref = 1'b0;
  logic [3:0]  fill_idx = '0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  logic        s_hit, s_miss, s_wprot, s_dirty, s_ref;
  logic [29:0] s_pa;
  logic [3:0]  s_idx;

  always #2 clk = ~clk;

  tlb_xlate #(.NUM_ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
    .hit_o(hit), .paddr_o(paddr), .hit_idx_o(hidx), .hit_dirty_o(hdirty), .hit_ref_o(href),
    .miss_exc_o(miss), .wprot_exc_o(wprot),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .fill_wr_ok_i(fill_wr_ok),
    .flush_i(flush), .clr_ref_i(clr_ref)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic sample();
    s_hit = hit; s_miss = miss; s_wprot = wprot; s_pa = paddr;
    s_idx = hidx; s_dirty = hdirty; s_ref = href;
  endtask

  // all tasks start and end at a falling edge with inputs idle
  task automatic access(input bit w, input logic [31:0] va, input bit clr = 1'b0);
    req_valid = 1'b1; req_write = w; req_vaddr = va; clr_ref = clr;
    #1 sample();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; clr_ref = 1'b0;
  endtask

  task automatic set_fill(input logic [3:0] idx, input logic [19:0] vpn,
                          input logic [17:0] ppn, input bit wr);
    fill_valid = 1'b1; fill_idx = idx; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wr;
  endtask

  task automatic fill(input logic [3:0] idx, input logic [19:0] vpn,
                      input logic [17:0] ppn, input bit wr);
    set_fill(idx, vpn, ppn, wr);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R5 idle hit", hit, 0);
    chk("R5 idle miss", miss, 0);
    chk("R5 idle paddr", paddr, 0);
    access(1'b0, 32'h1234_5678);
    chk("R1 miss after reset", s_miss, 1);
    chk("R1 no hit after reset", s_hit, 0);
    chk("R1 paddr zero", s_pa, 0);
  endtask

  task automatic t_basic_hit();
    fill(4'd3, 20'h12345, 18'h2ABCD, 1'b1);
    access(1'b0, 32'h1234_5678);
    chk("R2 hit", s_hit, 1);
    chk("R2 paddr", s_pa, {18'h2ABCD, 12'h678});
    chk("R8 slot", s_idx, 3);
    chk("R8 fresh dirty", s_dirty, 0);
    chk("R8 fresh ref", s_ref, 0);
    access(1'b0, 32'h1234_5ABC);
    chk("R2 paddr other offset", s_pa, {18'h2ABCD, 12'hABC});
    chk("R7 ref set by hit", s_ref, 1);
  endtask

  task automatic t_miss();
    access(1'b1, 32'h5432_1000);
    chk("R3 miss", s_miss, 1);
    chk("R3 no hit", s_hit, 0);
    chk("R3 paddr zero", s_pa, 0);
    chk("R5 no wprot on miss", s_wprot, 0);
  endtask

  task automatic t_prot();
    fill(4'd5, 20'h0C000, 18'h00111, 1'b0);
    access(1'b1, 32'h0C00_0200);
    chk("R4 wprot", s_wprot, 1);
    chk("R4 no hit", s_hit, 0);
    chk("R4 no miss", s_miss, 0);
    chk("R4 paddr zero", s_pa, 0);
    access(1'b0, 32'h0C00_0200);
    chk("R4 read hits", s_hit, 1);
    chk("R4 read paddr", s_pa, {18'h00111, 12'h200});
    chk("R4 dirty untouched", s_dirty, 0);
    chk("R4 ref untouched", s_ref, 0);
  endtask

  task automatic t_dirty();
    access(1'b1, 32'h1234_5010);
    chk("R6 write hits", s_hit, 1);
    chk("R6 dirty before write", s_dirty, 0);
    access(1'b0, 32'h1234_5010);
    chk("R6 dirty after write", s_dirty, 1);
  endtask

  task automatic t_clr_ref();
    clr_ref = 1'b1;
    @(negedge clk);
    clr_ref = 1'b0;
    access(1'b0, 32'h1234_5000);
    chk("R7 ref cleared", s_ref, 0);
    access(1'b0, 32'h1234_5000, 1'b1);
    access(1'b0, 32'h1234_5000);
    chk("R7 hit beats clear", s_ref, 1);
  endtask

  task automatic t_dup();
    fill(4'd7, 20'h12345, 18'h3F000, 1'b1);
    access(1'b0, 32'h1234_5444);
    chk("R9 new slot wins", s_idx, 7);
    chk("R9 new frame", s_pa, {18'h3F000, 12'h444});
  endtask

  task automatic t_fill_same_cycle();
    set_fill(4'd9, 20'h0AAAA, 18'h01234, 1'b1);
    access(1'b0, 32'h0AAA_A008);
    fill_valid = 1'b0;
    chk("R10 lookup sees old contents", s_miss, 1);
    access(1'b0, 32'h0AAA_A008);
    chk("R10 visible next cycle", s_pa, {18'h01234, 12'h008});
  endtask

  task automatic t_fill_beats_update();
    set_fill(4'd9, 20'h0AAAA, 18'h05555, 1'b1);
    access(1'b1, 32'h0AAA_A000);
    fill_valid = 1'b0;
    chk("R12 access hit old entry", s_pa, {18'h01234, 12'h000});
    access(1'b0, 32'h0AAA_A000);
    chk("R12 new frame", s_pa, {18'h05555, 12'h000});
    chk("R12 dirty cleared", s_dirty, 0);
    chk("R12 ref cleared", s_ref, 0);
  endtask

  task automatic t_flush();
    flush = 1'b1;
    set_fill(4'd2, 20'h01111, 18'h00222, 1'b1);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    access(1'b0, 32'h0AAA_A000);
    chk("R11 flushed entry misses", s_miss, 1);
    access(1'b0, 32'h0111_1000);
    chk("R11 fill dropped", s_miss, 1);
    access(1'b0, 32'h1234_5000);
    chk("R11 all gone", s_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_hit();
    t_miss();
    t_prot();
    t_dirty();
    t_clr_ref();
    t_dup();
    t_fill_same_cycle();
    t_fill_beats_update();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule